// File: doc/BRIEF.md
# Two-Cycle Wide Ternary Search Engine

This block is a small ternary search core holding sixteen 136-bit entries. A search key arrives in two consecutive command cycles, 68 bits at a time: the upper key half first, the lower half second. Each half is masked by one register of a selected global-mask pair, and by each entry's own per-bit care mask, before it is compared against the matching half of every entry. An entry hits only when both halves match and it is valid. The lowest-indexed hitting entry wins.

The side fields of a search are spread over the two command words. The first word picks the global-mask pair and a three-bit address prefix. The second word picks the comparand pair that keeps the whole key and the result register that keeps the outcome. The outcome leaves on an SRAM-read-style port (address, active-low chip enable, active-low address latch enable, active-low write enable held high) together with a one-cycle valid strobe and a hit flag, at a fixed latency. A plain write port loads entries and global-mask pairs. A combinational read port exposes the comparand and result registers.

The controller has two states. `ST_IDLE` waits for a first half: a valid search word with bit 2 clear moves it to `ST_SECOND`, and anything else keeps it in `ST_IDLE`. `ST_SECOND` always returns to `ST_IDLE`. It completes the search if the word is a valid search command, and otherwise abandons it.

Top module: `wide_tcam_search`

## Requirements
- R1: While reset is held and after it is released, srch_valid and srch_flag are 0, sram_ce_n, sram_ale_n and sram_we_n are 1, sram_addr is 0, and every comparand and result register reads 0. Global-mask pairs reset to all ones.
- R2: A search is a cycle with cmd_valid=1, cmd[1:0]=2'b10 and cmd[2]=0 (first half), followed at once by a cycle with cmd_valid=1 and cmd[1:0]=2'b10 (second half). srch_valid is 1 for exactly one cycle, the fourth cycle after the second half.
- R3: The first-half dq is key[135:68] and is compared against bits [135:68] of each entry. The second-half dq is key[67:0] and is compared against bits [67:0]. A valid entry hits when every compared bit matches in both halves.
- R4: First-half cmd[5:3] selects a global-mask pair. Bits [135:68] of the pair mask the first half and bits [67:0] mask the second half. A mask bit of 0 makes that key bit a don't-care.
- R5: A care bit of 0 in an entry makes that bit a don't-care for that entry. An entry written with wr_entry_valid=0 never hits.
- R6: When several entries hit, the lowest index wins.
- R7: On a hit, during the result cycle srch_flag=1, sram_ce_n=0, sram_ale_n=0, sram_addr[21:19] = first-half cmd[8:6], and sram_addr[18:0] = 2 × winning index. sram_we_n is 1 at all times.
- R8: On a miss, during the result cycle srch_valid=1, srch_flag=0, sram_ce_n=1, sram_ale_n=1 and sram_addr=0.
- R9: Second-half cmd[5:2] selects a comparand pair, which stores {first dq, second dq}. It reads on rd_data with rd_target=0 and rd_addr = the pair index.
- R10: Second-half cmd[8:6] selects a result register, which stores {hit, sram address} in bits [22:0] (all zero on a miss). It reads with rd_target=1 and rd_addr[2:0] = the register index.
- R11: A first half with cmd[2]=1, or a second cycle that is not a valid search word, produces no strobe and changes no comparand or result register. Valid command words with cmd[1:0] other than 2'b10 are ignored in `ST_IDLE`.
- R12: Searches may be issued back to back, one every two cycles, and each yields its own result cycle and register update.
- R13: A write with wr_en=1 stores into entry wr_addr when wr_target=0 (data, care, valid). When wr_target=1 it stores wr_data into global-mask pair wr_addr[2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word valid |
| cmd | input | 9 | Command word: code in [1:0], side fields above |
| dq | input | 68 | Key half for the current command cycle |
| wr_en | input | 1 | Write strobe |
| wr_target | input | 1 | 0 entry, 1 global-mask pair |
| wr_addr | input | 4 | Entry index or mask pair index |
| wr_data | input | 136 | Entry data or mask pair value |
| wr_care | input | 136 | Entry care mask (1 = compare) |
| wr_entry_valid | input | 1 | Valid bit written with an entry |
| rd_target | input | 1 | 0 comparand pair, 1 result register |
| rd_addr | input | 4 | Read index |
| rd_data | output | 136 | Read value |
| sram_addr | output | 22 | Result address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_ale_n | output | 1 | Address latch enable, active low |
| sram_we_n | output | 1 | Write enable, held inactive |
| srch_valid | output | 1 | Search result strobe |
| srch_flag | output | 1 | Hit flag |

## Verification
The comparand and result registers take their new values on the clock edge that ends the second command cycle, so the bench reads them back at any later falling edge. The port strobe, flag and SRAM fields are due in the fourth cycle after the second half. The bench records the cycle count when it drives each second half and books an expected result four cycles later. A monitor then compares the outputs at every falling edge, and a strobe at any unbooked cycle, or a missing strobe, is a miscompare. Abandoned searches book nothing, so a stray strobe is caught the same way.

// File: rtl/wts_pkg.sv
package wts_pkg;
    localparam logic [1:0] CMD_SEARCH = 2'b10;
    localparam int unsigned GM_PAIRS  = 8;
    localparam int unsigned CMP_PAIRS = 16;
    localparam int unsigned RES_REGS  = 8;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SECOND = 1'b1
    } srch_state_e;

    typedef enum logic {
        WT_ENTRY = 1'b0,
        WT_GMASK = 1'b1
    } wr_target_e;
endpackage

// File: rtl/wts_search_ctrl.sv
module wts_search_ctrl
    import wts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [8:0] cmd,
    output logic       take_a,
    output logic       take_b,
    output logic [2:0] gpair_q,
    output logic [2:0] prefix_q
);
    srch_state_e state, state_d;
    logic        is_search;

    always_comb is_search = cmd_valid && (cmd[1:0] == CMD_SEARCH);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        take_a  = 1'b0;
        take_b  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (is_search && !cmd[2]) begin
                    take_a  = 1'b1;
                    state_d = ST_SECOND;
                end
            end
            ST_SECOND: begin
                take_b  = is_search;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gpair_q  <= '0;
            prefix_q <= '0;
        end else if (take_a) begin
            gpair_q  <= cmd[5:3];
            prefix_q <= cmd[8:6];
        end
    end

    // R12: the second-half state never lasts more than one cycle
    p_second_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SECOND) |=> (state == ST_IDLE));
    // R2: a completed search always follows an accepted first half
    p_b_follows_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_b |-> $past(take_a));
    // R11: a first half with bit 2 set leaves the controller idle
    p_bad_first_rejected_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd[2]) |=> (state == ST_IDLE));
endmodule

// File: rtl/wts_entry_array.sv
module wts_entry_array #(
    parameter int HALF_W  = 68,
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [2*HALF_W-1:0] wr_data,
    input  logic [2*HALF_W-1:0] wr_care,
    input  logic                wr_valid,
    input  logic [HALF_W-1:0]   key_hi,
    input  logic [HALF_W-1:0]   mask_hi,
    input  logic [HALF_W-1:0]   key_lo,
    input  logic [HALF_W-1:0]   mask_lo,
    output logic [ENTRIES-1:0]  hit_hi,
    output logic [ENTRIES-1:0]  hit_lo
);
    localparam int KEY_W = 2 * HALF_W;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic [KEY_W-1:0] data_q;
        logic [KEY_W-1:0] care_q;
        logic             vld_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q <= '0;
                care_q <= '0;
                vld_q  <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                data_q <= wr_data;
                care_q <= wr_care;
                vld_q  <= wr_valid;
            end
        end

        assign hit_hi[e] = vld_q &&
            (((key_hi ^ data_q[KEY_W-1:HALF_W]) & mask_hi & care_q[KEY_W-1:HALF_W]) == '0);
        assign hit_lo[e] = vld_q &&
            (((key_lo ^ data_q[HALF_W-1:0]) & mask_lo & care_q[HALF_W-1:0]) == '0);
    end
endmodule

// File: rtl/wts_result_pipe.sv
module wts_result_pipe #(
    parameter int ADDR_W = 22,
    parameter int LAT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_hit,
    input  logic [ADDR_W-1:0] in_addr,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_ale_n,
    output logic              sram_we_n,
    output logic              srch_valid,
    output logic              srch_flag
);
    logic [LAT-1:0]    stg_v;
    logic [LAT-1:0]    stg_h;
    logic [ADDR_W-1:0] stg_a [LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_v[0] <= 1'b0;
            stg_h[0] <= 1'b0;
            stg_a[0] <= '0;
        end else begin
            stg_v[0] <= in_valid;
            stg_h[0] <= in_valid && in_hit;
            stg_a[0] <= (in_valid && in_hit) ? in_addr : '0;
        end
    end

    for (genvar j = 1; j < LAT; j++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_v[j] <= 1'b0;
                stg_h[j] <= 1'b0;
                stg_a[j] <= '0;
            end else begin
                stg_v[j] <= stg_v[j-1];
                stg_h[j] <= stg_h[j-1];
                stg_a[j] <= stg_a[j-1];
            end
        end
        // R2: a result advances one stage per cycle
        p_stage_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
            stg_v[j-1] |=> stg_v[j]);
    end

    always_comb begin
        srch_valid = stg_v[LAT-1];
        srch_flag  = stg_h[LAT-1];
        sram_ce_n  = ~stg_h[LAT-1];
        sram_ale_n = ~stg_h[LAT-1];
        sram_addr  = stg_a[LAT-1];
        sram_we_n  = 1'b1;
    end

    // R2: the result strobe is a single-cycle pulse
    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        srch_valid |=> !srch_valid);
    // R7: the hit flag only rides on a result strobe
    p_flag_in_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        srch_flag |-> srch_valid);
    // R8: a miss keeps the SRAM side quiet
    p_miss_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_valid && !srch_flag) |-> (sram_ce_n && sram_ale_n && (sram_addr == '0)));
endmodule

// File: rtl/wide_tcam_search.sv
module wide_tcam_search
    import wts_pkg::*;
#(
    parameter int HALF_W   = 68,
    parameter int ENTRIES  = 16,
    parameter int ADDR_W   = 22,
    parameter int PIPE_LAT = 4,
    parameter int SEL_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [8:0]          cmd,
    input  logic [HALF_W-1:0]   dq,
    input  logic                wr_en,
    input  logic                wr_target,
    input  logic [SEL_W-1:0]    wr_addr,
    input  logic [2*HALF_W-1:0] wr_data,
    input  logic [2*HALF_W-1:0] wr_care,
    input  logic                wr_entry_valid,
    input  logic                rd_target,
    input  logic [SEL_W-1:0]    rd_addr,
    output logic [2*HALF_W-1:0] rd_data,
    output logic [ADDR_W-1:0]   sram_addr,
    output logic                sram_ce_n,
    output logic                sram_ale_n,
    output logic                sram_we_n,
    output logic                srch_valid,
    output logic                srch_flag
);
    localparam int KEY_W = 2 * HALF_W;
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int LOW_W = ADDR_W - 3;
    localparam int PAD_W = LOW_W - IDX_W - 1;

    logic                take_a, take_b;
    logic [2:0]          gpair_q, prefix_q;
    logic [KEY_W-1:0]    gm_q      [GM_PAIRS];
    logic [KEY_W-1:0]    cmp_q     [CMP_PAIRS];
    logic [RES_REGS-1:0] res_hit_q;
    logic [ADDR_W-1:0]   res_addr_q [RES_REGS];
    logic [KEY_W-1:0]    gm_first, gm_second;
    logic [ENTRIES-1:0]  hi_vec, lo_vec, hi_vec_q, match_vec;
    logic [HALF_W-1:0]   key_hi_q;
    logic [IDX_W-1:0]    win_idx;
    logic                any_hit;
    logic [ADDR_W-1:0]   win_addr;

    wts_search_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd      (cmd),
        .take_a   (take_a),
        .take_b   (take_b),
        .gpair_q  (gpair_q),
        .prefix_q (prefix_q)
    );

    always_comb begin
        gm_first  = gm_q[cmd[5:3]];
        gm_second = gm_q[gpair_q];
    end

    wts_entry_array #(.HALF_W(HALF_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && (wr_target == WT_ENTRY)),
        .wr_idx  (wr_addr[IDX_W-1:0]),
        .wr_data (wr_data),
        .wr_care (wr_care),
        .wr_valid(wr_entry_valid),
        .key_hi  (dq),
        .mask_hi (gm_first[KEY_W-1:HALF_W]),
        .key_lo  (dq),
        .mask_lo (gm_second[HALF_W-1:0]),
        .hit_hi  (hi_vec),
        .hit_lo  (lo_vec)
    );

    // global-mask pairs: upper half masks the first cycle, lower half the second
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < int'(GM_PAIRS); p++) gm_q[p] <= '1;
        end else if (wr_en && (wr_target == WT_GMASK)) begin
            gm_q[wr_addr[2:0]] <= wr_data;
        end
    end

    // first-half state kept for the second cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_vec_q <= '0;
            key_hi_q <= '0;
        end else if (take_a) begin
            hi_vec_q <= hi_vec;
            key_hi_q <= dq;
        end
    end

    always_comb begin
        match_vec = hi_vec_q & lo_vec;
        any_hit   = |match_vec;
        win_idx   = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (match_vec[e]) win_idx = IDX_W'(e);
        end
        win_addr = {prefix_q, {PAD_W{1'b0}}, win_idx, 1'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < int'(CMP_PAIRS); c++) cmp_q[c] <= '0;
            for (int r = 0; r < int'(RES_REGS); r++) res_addr_q[r] <= '0;
            res_hit_q <= '0;
        end else if (take_b) begin
            cmp_q[cmd[5:2]]      <= {key_hi_q, dq};
            res_hit_q[cmd[8:6]]  <= any_hit;
            res_addr_q[cmd[8:6]] <= any_hit ? win_addr : '0;
        end
    end

    always_comb begin
        if (rd_target) rd_data = {{(KEY_W-ADDR_W-1){1'b0}}, res_hit_q[rd_addr[2:0]], res_addr_q[rd_addr[2:0]]};
        else           rd_data = cmp_q[rd_addr];
    end

    wts_result_pipe #(.ADDR_W(ADDR_W), .LAT(PIPE_LAT)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (take_b),
        .in_hit    (any_hit),
        .in_addr   (win_addr),
        .sram_addr (sram_addr),
        .sram_ce_n (sram_ce_n),
        .sram_ale_n(sram_ale_n),
        .sram_we_n (sram_we_n),
        .srch_valid(srch_valid),
        .srch_flag (srch_flag)
    );

    // R11: result registers change only on a completed search
    p_res_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !take_b |=> $stable(res_hit_q));
    // R6: a recorded winner had its first half matching
    p_winner_first_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_b && any_hit) |-> hi_vec_q[win_idx]);
endmodule

// File: tb/wide_tcam_search_bench.sv
module wide_tcam_search_bench;
    localparam int HW = 68;
    localparam int KW = 136;
    localparam int N  = 16;
    localparam int SL = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [8:0]    cmd = '0;
    logic [HW-1:0] dq = '0;
    logic          wr_en = 1'b0;
    logic          wr_target = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [KW-1:0] wr_data = '0;
    logic [KW-1:0] wr_care = '0;
    logic          wr_entry_valid = 1'b0;
    logic          rd_target = 1'b0;
    logic [3:0]    rd_addr = '0;
    logic [KW-1:0] rd_data;
    logic [21:0]   sram_addr;
    logic          sram_ce_n, sram_ale_n, sram_we_n, srch_valid, srch_flag;

    always #4 clk = ~clk;

    wide_tcam_search u_wide_tcam_search (.*);

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    int          cyc = 0;
    bit          finished = 1'b0;

    logic [KW-1:0] m_data [N];
    logic [KW-1:0] m_care [N];
    bit            m_vld  [N];
    logic [KW-1:0] m_gm   [8];
    logic [KW-1:0] m_cmp  [16];
    logic [22:0]   m_res  [8];
    int            e_at   [SL];
    bit            e_h    [SL];
    logic [21:0]   e_a    [SL];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [KW-1:0] act, input logic [KW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // result monitor: every booked cycle must show a strobe, and no other cycle may
    always @(negedge clk) begin
        int  s;
        bit  ev;
        if (rst_n) begin
            s  = cyc % SL;
            ev = (e_at[s] == cyc);
            if (ev || srch_valid) begin
                chk("R2 srch_valid", KW'(srch_valid), KW'(ev));
                chk("R7 srch_flag", KW'(srch_flag), KW'(ev && e_h[s]));
                chk("R7 sram_addr", KW'(sram_addr), KW'((ev && e_h[s]) ? e_a[s] : 22'd0));
                chk("R8 sram_ce_n", KW'(sram_ce_n), KW'(!(ev && e_h[s])));
                chk("R8 sram_ale_n", KW'(sram_ale_n), KW'(!(ev && e_h[s])));
                chk("R7 sram_we_n", KW'(sram_we_n), KW'(1'b1));
            end
        end
    end

    function automatic logic [KW-1:0] pat(input int i);
        logic [31:0] w;
        w = 32'h9E3779B9 * (i + 1);
        return {8'(i * 29 + 3), w, w ^ 32'h5A5A5A5A, {w[15:0], w[31:16]}, ~w};
    endfunction

    task automatic model_search(input logic [2:0] gp, input logic [KW-1:0] key,
                                output bit hit, output int idx);
        hit = 1'b0;
        idx = 0;
        for (int e = N - 1; e >= 0; e--) begin
            if (m_vld[e] && (((key ^ m_data[e]) & m_care[e] & m_gm[gp]) == '0)) begin
                hit = 1'b1;
                idx = e;
            end
        end
    endtask

    task automatic wr_entry(input int i, input logic [KW-1:0] d, input logic [KW-1:0] c, input bit v);
        wr_en = 1'b1; wr_target = 1'b0; wr_addr = 4'(i);
        wr_data = d; wr_care = c; wr_entry_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
        m_data[i] = d; m_care[i] = c; m_vld[i] = v;
    endtask

    task automatic wr_gmask(input int p, input logic [KW-1:0] g);
        wr_en = 1'b1; wr_target = 1'b1; wr_addr = 4'(p); wr_data = g;
        @(negedge clk);
        wr_en = 1'b0;
        m_gm[p] = g;
    endtask

    // bad: 0 legal, 1 first half with bit 2 set, 2 wrong code in second, 3 no valid in second
    task automatic search(input logic [2:0] gp, input logic [2:0] pfx, input logic [3:0] cp,
                          input logic [2:0] ssr, input logic [KW-1:0] key, input int bad, input bit gap);
        bit          hit;
        int          idx;
        logic [21:0] a;
        cmd_valid = 1'b1;
        cmd = {pfx, gp, (bad == 1), 2'b10};
        dq = key[135:68];
        @(negedge clk);
        cmd_valid = (bad != 3);
        cmd = {ssr, cp, (bad == 2) ? 2'b01 : 2'b10};
        dq = key[67:0];
        if (bad == 0) begin
            model_search(gp, key, hit, idx);
            a = {pfx, 19'(idx * 2)};
            e_at[(cyc + 4) % SL] = cyc + 4;
            e_h[(cyc + 4) % SL]  = hit;
            e_a[(cyc + 4) % SL]  = a;
            m_cmp[cp] = key;
            m_res[ssr] = hit ? {1'b1, a} : 23'd0;
        end
        @(negedge clk);
        if (gap) begin
            cmd_valid = 1'b0; cmd = '0; dq = '0;
            @(negedge clk);
        end
    endtask

    task automatic rd_all(input string req);
        for (int c = 0; c < 16; c++) begin
            rd_target = 1'b0; rd_addr = 4'(c); #1;
            chk({req, " R9 comparand"}, rd_data, m_cmp[c]);
        end
        for (int r = 0; r < 8; r++) begin
            rd_target = 1'b1; rd_addr = 4'(r); #1;
            chk({req, " R10 result"}, rd_data, KW'(m_res[r]));
        end
    endtask

    task automatic idle(input int n);
        cmd_valid = 1'b0; cmd = '0; dq = '0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
        end
    end

    initial begin
        logic [KW-1:0] k;
        logic [KW-1:0] care;
        for (int s = 0; s < SL; s++) begin e_at[s] = -1; e_h[s] = 1'b0; e_a[s] = '0; end
        for (int e = 0; e < N; e++) begin m_data[e] = '0; m_care[e] = '0; m_vld[e] = 1'b0; end
        for (int p = 0; p < 8; p++) begin m_gm[p] = '1; m_res[p] = '0; end
        for (int c = 0; c < 16; c++) m_cmp[c] = '0;

        // R1: reset state, during and after reset
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", KW'(srch_valid), '0);
        chk("R1 ce_n in reset", KW'(sram_ce_n), KW'(1'b1));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flag", KW'(srch_flag), '0);
        chk("R1 ale_n", KW'(sram_ale_n), KW'(1'b1));
        chk("R1 we_n", KW'(sram_we_n), KW'(1'b1));
        chk("R1 addr", KW'(sram_addr), '0);
        rd_all("R1");

        // R13 load: every entry valid except 13
        for (int i = 0; i < N; i++) wr_entry(i, pat(i), '1, i != 13);

        // R3 exact keys for every entry, R5 for the invalid one
        for (int i = 0; i < N; i++)
            search(3'(i), 3'(i + 2), 4'(15 - i), 3'(i), pat(i), 0, 1);
        idle(6);
        rd_all("R3");

        // R3 single-bit mismatches across both halves: all misses
        for (int b = 0; b < KW; b += 9) begin
            k = pat(2) ^ (KW'(1) << b);
            search(3'(b), 3'(b), 4'(b), 3'(b + 1), k, 0, 1);
        end
        idle(6);

        // R4 global-mask pairs with one cleared bit each (R13 write path)
        for (int p = 0; p < 8; p++) wr_gmask(p, ~(KW'(1) << (p * 17)));
        for (int p = 0; p < 8; p++) begin
            k = pat(5) ^ (KW'(1) << (p * 17));
            search(3'(p), 3'(p), 4'(p), 3'(p), k, 0, 1);
            search(3'(p + 1), 3'(7 - p), 4'(p + 8), 3'(7 - p), k, 0, 1);
        end
        idle(6);
        rd_all("R4");

        // R5 local care mask clearing the bottom 41 bits of entry 9
        care = ~KW'(41'h1FF_FFFF_FFFF);
        wr_entry(9, pat(9), care, 1'b1);
        search(3'd1, 3'd4, 4'd3, 3'd2, pat(9) ^ KW'(41'h0AB_CDEF_1234), 0, 1);
        search(3'd1, 3'd4, 4'd4, 3'd3, pat(9) ^ (KW'(1) << 100), 0, 1);
        idle(6);
        rd_all("R5");

        // R6 priority among duplicates, then after invalidating winners
        wr_entry(4, pat(40), '1, 1'b1);
        wr_entry(7, pat(40), '1, 1'b1);
        wr_entry(12, pat(40), '1, 1'b1);
        search(3'd2, 3'd6, 4'd0, 3'd0, pat(40), 0, 1);
        wr_entry(4, pat(40), '1, 1'b0);
        search(3'd2, 3'd6, 4'd1, 3'd1, pat(40), 0, 1);
        wr_entry(7, pat(40), '1, 1'b0);
        search(3'd2, 3'd6, 4'd2, 3'd2, pat(40), 0, 1);
        idle(6);
        rd_all("R6");

        // R11 protocol violations and ignored commands
        search(3'd0, 3'd1, 4'd5, 3'd5, pat(0), 1, 1);
        search(3'd0, 3'd1, 4'd6, 3'd6, pat(0), 2, 1);
        search(3'd0, 3'd1, 4'd7, 3'd7, pat(0), 3, 1);
        for (int c = 0; c < 4; c++) begin
            if (c == 2) continue;
            cmd_valid = 1'b1; cmd = {7'h55, 2'(c)}; dq = pat(1)[135:68];
            @(negedge clk);
            cmd_valid = 1'b1; cmd = {7'h2A, 2'(c)}; dq = pat(1)[67:0];
            @(negedge clk);
        end
        idle(6);
        rd_all("R11");

        // R12 back-to-back searches, one every two cycles
        for (int i = 0; i < 8; i++)
            search(3'(i), 3'(7 - i), 4'(i + 4), 3'(i), pat(i + 1), 0, 0);
        idle(8);
        rd_all("R12");

        finished = 1'b0;
        report();
    end
endmodule